// File: doc/BRIEF.md
# Atomic Read-Modify-Write Datapath

This block computes both results of an atomic read-modify-write. From an operation code, an access width, the register operand and the data read from memory, it produces two values. The first is the value to write back to memory, cut to the access width, with a byte-lane mask beside it. The second is the value returned to the destination register. Load/store control sits around this block and provides the memory traffic, address handling and fault reporting. The block only does the arithmetic, comparison and extension work between the read and the write.

Before the operation, both operands are brought to full datapath width at the access width. The two unsigned compare operations zero-extend them and every other operation sign-extends them. The returned register value does not depend on the operation. It is always the loaded data sign-extended from the access width. All outputs are registered, so they show the inputs presented one clock earlier. The datapath width `XLEN` is 32 or 64.

Top module: `amo_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output (`store_data`, `store_mask`, `ret_data`, `bad_op`, `bad_width`) is cleared to zero after that edge.
- R2: Outputs reflect the inputs sampled at the previous rising edge. They hold steady between edges whatever the inputs do.
- R3: Operation code 0 (swap) stores the register operand, cut to the access width. Access width codes are 0=byte, 1=half, 2=word, 3=double.
- R4: Operation code 1 (add) stores the sum of the extended operands modulo 2 to the power of the access width in bits. No carry is reported.
- R5: Codes 2, 3 and 4 store the bitwise XOR, AND and OR of the register operand and the loaded data.
- R6: Codes 5 (min) and 6 (max) compare the operands as two's-complement numbers of the access width. They store the smaller or the larger one.
- R7: Codes 7 (unsigned min) and 8 (unsigned max) compare the operands as unsigned numbers of the access width. They store the smaller or the larger one.
- R8: `store_data` carries the result in its low 8, 16, 32 or 64 bits and zero above them. `store_mask` has its low 1, 2, 4 or 8 bits set, one per byte lane written.
- R9: `ret_data` is the loaded data's low byte, half or word sign-extended to `XLEN`, for every operation. For a double access it is the loaded data unchanged.
- R10: Operation codes 9 to 15 set `bad_op`. In that case `store_data`, `store_mask` and `ret_data` are zero.
- R11: A double access with `XLEN` = 32 sets `bad_width` and zeroes `store_data`, `store_mask` and `ret_data`. With `XLEN` = 64 a double access is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 4 | Operation code (0..8 valid) |
| acc_width | input | 2 | Access width: 0 byte, 1 half, 2 word, 3 double |
| reg_opnd | input | XLEN | Register source operand |
| mem_load | input | XLEN | Data read from memory |
| store_data | output | XLEN | Value to write back, zero above access width |
| store_mask | output | XLEN/8 | Byte-lane write mask |
| ret_data | output | XLEN | Value for the destination register |
| bad_op | output | 1 | Unused operation code was presented |
| bad_width | output | 1 | Double access on a 32-bit datapath |

## Verification
The bench builds two copies side by side with identical stimulus: one with `XLEN` = 64 and one with `XLEN` = 32. The 64-bit copy exercises double accesses and sign extension of a word into the upper half. The 32-bit copy exercises the illegal-width path and shows that word accesses there fill the whole datapath with no extension. Directed corner values probe signed versus unsigned ordering, wrap-around on add and sign-bit propagation into the returned value. A sweep then covers every code and width against a model computed in the bench.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [3:0] {
    OP_SWAP = 4'd0,
    OP_ADD  = 4'd1,
    OP_XOR  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_MIN  = 4'd5,
    OP_MAX  = 4'd6,
    OP_MINU = 4'd7,
    OP_MAXU = 4'd8
  } amo_op_e;

  typedef enum logic [1:0] {
    ACC_B = 2'd0,
    ACC_H = 2'd1,
    ACC_W = 2'd2,
    ACC_D = 2'd3
  } acc_w_e;

  localparam int unsigned LAST_OP = 8;

  // Number of significant bits for an access width, clamped to the datapath.
  function automatic int unsigned keep_bits(input logic [1:0] w, input int unsigned xlen);
    int unsigned n;
    case (w)
      2'd0:    n = 8;
      2'd1:    n = 16;
      2'd2:    n = 32;
      default: n = 64;
    endcase
    return (n > xlen) ? xlen : n;
  endfunction

  function automatic logic op_unsigned(input logic [3:0] op);
    return (op == OP_MINU) || (op == OP_MAXU);
  endfunction

endpackage

// File: rtl/amo_extend.sv
module amo_extend #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] val_in,
  input  logic [1:0]      width,
  input  logic            zero_fill,
  output logic [XLEN-1:0] val_out
);
  import amo_pkg::*;

  localparam int unsigned SHW = $clog2(XLEN + 1);

  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] pushed;
  logic [XLEN-1:0] z_ext;
  logic [XLEN-1:0] s_ext;

  always_comb begin
    shamt  = SHW'(XLEN - keep_bits(width, XLEN));
    pushed = val_in << shamt;
    z_ext  = pushed >> shamt;
    s_ext  = XLEN'($signed(pushed) >>> shamt);
    val_out = zero_fill ? z_ext : s_ext;
  end

endmodule

// File: rtl/amo_op_unit.sv
module amo_op_unit #(
  parameter int unsigned XLEN = 64
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] result,
  output logic            op_illegal
);
  import amo_pkg::*;

  logic a_lt_s;
  logic a_lt_u;

  always_comb begin
    a_lt_s = $signed(src_a) < $signed(src_b);
    a_lt_u = src_a < src_b;
    op_illegal = 1'b0;
    case (op)
      OP_SWAP: result = src_a;
      OP_ADD:  result = src_a + src_b;
      OP_XOR:  result = src_a ^ src_b;
      OP_AND:  result = src_a & src_b;
      OP_OR:   result = src_a | src_b;
      OP_MIN:  result = a_lt_s ? src_a : src_b;
      OP_MAX:  result = a_lt_s ? src_b : src_a;
      OP_MINU: result = a_lt_u ? src_a : src_b;
      OP_MAXU: result = a_lt_u ? src_b : src_a;
      default: begin
        result     = '0;
        op_illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/amo_lane_pack.sv
module amo_lane_pack #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned MASKW = XLEN / 8
) (
  input  logic [1:0]       width,
  input  logic [XLEN-1:0]  result,
  output logic [XLEN-1:0]  st_data,
  output logic [MASKW-1:0] st_mask,
  output logic             width_bad
);
  import amo_pkg::*;

  localparam int unsigned SHW    = $clog2(XLEN + 1);
  localparam bit          DBL_OK = (XLEN == 64);

  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] low_ones;
  logic [8:0]      lane_run;

  always_comb begin
    shamt     = SHW'(XLEN - keep_bits(width, XLEN));
    low_ones  = {XLEN{1'b1}} >> shamt;
    st_data   = result & low_ones;
    lane_run  = (9'd1 << (keep_bits(width, XLEN) / 8)) - 9'd1;
    st_mask   = lane_run[MASKW-1:0];
    width_bad = (width == ACC_D) && !DBL_OK;
  end

endmodule

// File: rtl/amo_alu.sv
module amo_alu #(
  parameter int unsigned XLEN = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          op_sel,
  input  logic [1:0]          acc_width,
  input  logic [XLEN-1:0]     reg_opnd,
  input  logic [XLEN-1:0]     mem_load,
  output logic [XLEN-1:0]     store_data,
  output logic [XLEN/8-1:0]   store_mask,
  output logic [XLEN-1:0]     ret_data,
  output logic                bad_op,
  output logic                bad_width
);
  import amo_pkg::*;

  localparam int unsigned MASKW = XLEN / 8;

  logic            zfill;
  logic [XLEN-1:0] opnd_ext;
  logic [XLEN-1:0] load_ext;
  logic [XLEN-1:0] load_ret;
  logic [XLEN-1:0] op_res;
  logic            op_ill;
  logic [XLEN-1:0] st_d;
  logic [MASKW-1:0] st_m;
  logic            w_bad;
  logic            any_err;

  assign zfill = op_unsigned(op_sel);

  amo_extend #(.XLEN(XLEN)) u_ext_reg (
    .val_in(reg_opnd), .width(acc_width), .zero_fill(zfill), .val_out(opnd_ext)
  );

  amo_extend #(.XLEN(XLEN)) u_ext_load (
    .val_in(mem_load), .width(acc_width), .zero_fill(zfill), .val_out(load_ext)
  );

  amo_extend #(.XLEN(XLEN)) u_ext_ret (
    .val_in(mem_load), .width(acc_width), .zero_fill(1'b0), .val_out(load_ret)
  );

  amo_op_unit #(.XLEN(XLEN)) u_op (
    .op(op_sel), .src_a(opnd_ext), .src_b(load_ext), .result(op_res), .op_illegal(op_ill)
  );

  amo_lane_pack #(.XLEN(XLEN), .MASKW(MASKW)) u_pack (
    .width(acc_width), .result(op_res), .st_data(st_d), .st_mask(st_m), .width_bad(w_bad)
  );

  assign any_err = op_ill || w_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_data <= '0;
      store_mask <= '0;
      ret_data   <= '0;
      bad_op     <= 1'b0;
      bad_width  <= 1'b0;
    end else begin
      store_data <= any_err ? '0 : st_d;
      store_mask <= any_err ? '0 : st_m;
      ret_data   <= any_err ? '0 : load_ret;
      bad_op     <= op_ill;
      bad_width  <= w_bad;
    end
  end

  // Checker state: one clean cycle after reset before looking into the past.
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  logic [XLEN-1:0] lane_bits;
  for (genvar b = 0; b < MASKW; b++) begin : g_lane
    assign lane_bits[8*b +: 8] = {8{store_mask[b]}};
  end

  p_mask_contig_r8: assert property (@(posedge clk) disable iff (rst)
    ((store_mask & (store_mask + 1'b1)) == '0));

  p_store_in_lanes_r8: assert property (@(posedge clk) disable iff (rst)
    ((store_data & ~lane_bits) == '0));

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (bad_op || bad_width) |-> (store_data == '0 && store_mask == '0 && ret_data == '0));

  p_ret_sext_r9: assert property (@(posedge clk) disable iff (rst || !primed)
    (!bad_op && !bad_width && $past(acc_width) == 2'd0)
      |-> (ret_data == {{(XLEN-8){ret_data[7]}}, ret_data[7:0]}));

  p_width_src_r11: assert property (@(posedge clk) disable iff (rst || !primed)
    bad_width |-> ($past(acc_width) == 2'd3));

endmodule

// File: tb/test_amo_alu.sv
module test_amo_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op  = '0;
  logic [1:0]  wd  = '0;
  logic [63:0] rg  = '0;
  logic [63:0] ld  = '0;

  logic [63:0] sd64, rt64;
  logic [7:0]  mk64;
  logic        bo64, bw64;
  logic [31:0] sd32, rt32;
  logic [3:0]  mk32;
  logic        bo32, bw32;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #5 clk = ~clk;

  amo_alu #(.XLEN(64)) i_amo_alu (
    .clk(clk), .rst(rst), .op_sel(op), .acc_width(wd), .reg_opnd(rg), .mem_load(ld),
    .store_data(sd64), .store_mask(mk64), .ret_data(rt64), .bad_op(bo64), .bad_width(bw64)
  );

  amo_alu #(.XLEN(32)) i_amo_alu_x32 (
    .clk(clk), .rst(rst), .op_sel(op), .acc_width(wd), .reg_opnd(rg[31:0]), .mem_load(ld[31:0]),
    .store_data(sd32), .store_mask(mk32), .ret_data(rt32), .bad_op(bo32), .bad_width(bw32)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d w=%0d got=%h exp=%h", req, op, wd, got, exp);
    end
  endtask

  // Model built from the requirement text, in 64-bit arithmetic.
  function automatic void model(input int xl, input int o, input int w,
                                input logic [63:0] a_in, input logic [63:0] b_in,
                                output logic [63:0] e_sd, output logic [7:0] e_mk,
                                output logic [63:0] e_rt, output bit e_bo, output bit e_bw);
    int nb;
    logic [63:0] lm, a, b, r;
    bit uns;
    nb = 8 << w;
    lm = (nb == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << nb) - 64'd1);
    e_bo = (o > 8);
    e_bw = (w == 3) && (xl == 32);
    e_sd = '0; e_mk = '0; e_rt = '0;
    if (e_bo || e_bw) return;
    uns = (o == 7) || (o == 8);
    a = a_in & lm;
    b = b_in & lm;
    if (!uns && nb < 64 && a[nb-1]) a = a | ~lm;
    if (!uns && nb < 64 && b[nb-1]) b = b | ~lm;
    case (o)
      0: r = a;
      1: r = a + b;
      2: r = a ^ b;
      3: r = a & b;
      4: r = a | b;
      5: r = ($signed(a) < $signed(b)) ? a : b;
      6: r = ($signed(a) > $signed(b)) ? a : b;
      7: r = (a < b) ? a : b;
      default: r = (a > b) ? a : b;
    endcase
    e_sd = r & lm;
    e_mk = 8'((9'd1 << (nb / 8)) - 9'd1);
    e_rt = b_in & lm;
    if (nb < 64 && e_rt[nb-1]) e_rt = e_rt | ~lm;
  endfunction

  task automatic apply(input string req, input int o, input int w,
                       input logic [63:0] a, input logic [63:0] b);
    logic [63:0] es, er;
    logic [7:0]  em;
    bit eo, ew;
    @(negedge clk);
    op = 4'(o); wd = 2'(w); rg = a; ld = b;
    @(posedge clk);
    #1;
    model(64, o, w, a, b, es, em, er, eo, ew);
    chk({req, " x64 store"}, sd64, es);
    chk({req, " x64 mask"}, {56'd0, mk64}, {56'd0, em});
    chk({req, " x64 ret"}, rt64, er);
    chk({req, " x64 flags"}, {62'd0, bo64, bw64}, {62'd0, eo, ew});
    model(32, o, w, {32'd0, a[31:0]}, {32'd0, b[31:0]}, es, em, er, eo, ew);
    chk({req, " x32 store"}, {32'd0, sd32}, {32'd0, es[31:0]});
    chk({req, " x32 mask"}, {60'd0, mk32}, {60'd0, em[3:0]});
    chk({req, " x32 ret"}, {32'd0, rt32}, {32'd0, er[31:0]});
    chk({req, " x32 flags"}, {62'd0, bo32, bw32}, {62'd0, eo, ew});
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; op = 4'd15; wd = 2'd3; rg = '1; ld = '1;
    @(posedge clk); #1;
    chk("R1 store", sd64, '0);
    chk("R1 mask", {56'd0, mk64}, '0);
    chk("R1 ret", rt64, '0);
    chk("R1 flags", {60'd0, bo64, bw64, bo32, bw32}, '0);
    chk("R1 x32", {sd32, rt32}, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    logic [63:0] held;
    apply("R2", 1, 3, 64'h0000_0001_0000_0002, 64'h0000_0010_0000_0020);
    held = sd64;
    @(negedge clk);
    op = 4'd0; wd = 2'd0; rg = 64'hAB; ld = 64'h80;
    #1;
    chk("R2 hold store", sd64, held);
    chk("R2 hold ret", rt64, 64'h0000_0010_0000_0020);
  endtask

  task automatic t_swap;
    apply("R3", 0, 0, 64'h1234_5678_9ABC_DEF0, 64'h0);
    apply("R3", 0, 2, 64'hFFFF_FFFF_8000_0001, 64'h5);
    apply("R3", 0, 3, 64'hCAFE_F00D_1234_5678, 64'h7);
  endtask

  task automatic t_add;
    apply("R4", 1, 0, 64'hFF, 64'h01);
    apply("R4", 1, 1, 64'h8000, 64'h8000);
    apply("R4", 1, 2, 64'hFFFF_FFFF, 64'h2);
    apply("R4", 1, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3);
  endtask

  task automatic t_logic;
    apply("R5 xor", 2, 1, 64'h00FF_F0F0, 64'h0F0F_FF00);
    apply("R5 and", 3, 2, 64'hF0F0_F0F0, 64'hFF00_FF00);
    apply("R5 or", 4, 3, 64'h1000_0000_0000_0001, 64'h0200_0000_8000_0000);
  endtask

  task automatic t_signed;
    apply("R6 min", 5, 0, 64'h80, 64'h7F);
    apply("R6 max", 6, 0, 64'h80, 64'h7F);
    apply("R6 min", 5, 2, 64'h7FFF_FFFF, 64'h8000_0000);
    apply("R6 max", 6, 3, 64'h8000_0000_0000_0000, 64'h1);
  endtask

  task automatic t_unsigned;
    apply("R7 minu", 7, 0, 64'h80, 64'h7F);
    apply("R7 maxu", 8, 0, 64'h80, 64'h7F);
    apply("R7 minu", 7, 2, 64'h8000_0000, 64'h1);
    apply("R7 maxu", 8, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
  endtask

  task automatic t_ret;
    apply("R9 R8", 7, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FF80);
    apply("R9 R8", 2, 1, 64'h0, 64'h0000_0000_0001_8001);
    apply("R9 R8", 3, 2, 64'hFFFF, 64'h1_8000_0000);
    apply("R9 R8", 0, 3, 64'h0, 64'h8765_4321_0FED_CBA9);
  endtask

  task automatic t_badop;
    for (int o = 9; o < 16; o++) apply("R10", o, o % 4, 64'hDEAD_BEEF, 64'hFFFF_0000_8080);
  endtask

  task automatic t_narrow_double;
    apply("R11", 1, 3, 64'h1_0000_0001, 64'h2_0000_0002);
    apply("R11", 8, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
  endtask

  task automatic t_sweep;
    for (int o = 0; o < 9; o++) begin
      for (int w = 0; w < 4; w++) begin
        for (int k = 0; k < 3; k++) begin
          logic [63:0] a, b;
          lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
          a = lfsr;
          lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
          b = lfsr;
          apply("R3 R4 R5 R6 R7 R8 R9 R11 sweep", o, w, a, b);
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_latency;
    t_swap;
    t_add;
    t_logic;
    t_signed;
    t_unsigned;
    t_ret;
    t_badop;
    t_narrow_double;
    t_sweep;
    t_reset;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule